// File: doc/BRIEF.md
# Long-Immediate Instruction Execute Unit

This unit executes one 32-bit instruction class that names a source register, a destination register and a 16-bit constant. Depending on the primary opcode, the constant is sign-extended, zero-extended or placed in the upper half of the word. The unit then adds it to the source value, moves it straight into a data or address register, or uses it as the offset of a core special register that is read or written through a small request interface.

The surrounding pipeline reads the register file and presents the operand on `in_src` together with the instruction word and a valid strobe. For arithmetic operations this operand is the register named by bits 11:8. For a move-to-core-register it is the data register named by bits 31:28. One clock later the unit presents a registered write-back, flag updates, a core-register request or an illegal-opcode pulse. The unit also holds the two sticky overflow flags.

Top module: `limm_exec_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `wr_en`, `flag_upd`, `cr_rd_req`, `cr_wr_req`, `illegal`, `flag_sv` and `flag_sav` are all 0.
- R2: Every output effect appears exactly one clock after the edge that samples `in_valid` high. A cycle with `in_valid` low produces no write, no flag update, no request and no illegal pulse.
- R3: Field positions are opcode 7:0, constant 27:12 and destination 31:28. Opcode 0x10 writes `in_src` plus the sign-extended constant to data register destination and updates the flags.
- R4: Opcode 0x11 writes `in_src` plus (constant << 16) to a data register and updates the flags.
- R5: Opcode 0x12 writes `in_src` plus (constant << 16) to an address register (`wr_addr_file`=1) with no flag update, leaving the sticky flags unchanged.
- R6: Opcode 0x13 writes the sign-extended constant to a data register. Opcode 0x14 writes the zero-extended constant to a data register.
- R7: Opcode 0x15 writes (constant << 16) to a data register. Opcode 0x16 writes the same value to an address register.
- R8: On a flag update, `flag_v` is 1 exactly when the signed 32-bit sum overflows, and `flag_av` equals result bit 31 XOR bit 30. `flag_sv` and `flag_sav` accumulate these by OR and are cleared only by reset.
- R9: Opcode 0x17 raises `cr_rd_req` with `cr_addr` equal to the constant. In that same cycle, `wr_data` carries `cr_rdata` to a data register.
- R10: Opcode 0x18 raises `cr_wr_req` with `cr_addr` equal to the constant and `cr_wdata` equal to `in_src`, and performs no register write.
- R11: Any other opcode raises `illegal` for one cycle, with no write, no flag update and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction valid strobe |
| in_instr | input | 32 | Instruction word |
| in_src | input | 32 | Operand read from the register file |
| cr_rdata | input | 32 | Core register read data, same cycle as `cr_rd_req` |
| wr_en | output | 1 | Register write enable |
| wr_addr_file | output | 1 | 1 = address register file, 0 = data register file |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Write-back value |
| flag_upd | output | 1 | Arithmetic flags updated this cycle |
| flag_v | output | 1 | Overflow |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance overflow |
| flag_sav | output | 1 | Sticky advance overflow |
| cr_rd_req | output | 1 | Core register read request |
| cr_wr_req | output | 1 | Core register write request |
| cr_addr | output | 16 | Core register offset |
| cr_wdata | output | 32 | Core register write data |
| illegal | output | 1 | Unrecognised opcode pulse |

## Verification
The assertions assume that `in_valid` is held low while reset is asserted. They also assume that the responder returns `cr_rdata` combinationally in the cycle of `cr_rd_req`, and that `in_valid` and `in_instr` change only between clock edges. The bench drives every input shortly after the falling edge and keeps `in_valid` at 0 through both reset pulses. Its core-register responder derives `cr_rdata` purely from `cr_addr`, so each read's data is known at the moment it is requested.

// File: rtl/limm_pkg.sv
`timescale 1ns/1ps
package limm_pkg;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = 4;
  localparam int CONST_W   = 16;
  localparam int OPC_W     = 8;
  localparam int SRC_LSB   = 8;
  localparam int CONST_LSB = 12;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD_IMM     = 8'h10,
    OPC_ADD_HI      = 8'h11,
    OPC_ADD_HI_ADR  = 8'h12,
    OPC_MOV_S       = 8'h13,
    OPC_MOV_Z       = 8'h14,
    OPC_MOV_HI      = 8'h15,
    OPC_MOV_HI_ADR  = 8'h16,
    OPC_CR_READ     = 8'h17,
    OPC_CR_WRITE    = 8'h18
  } opc_e;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_ADD   = 3'd1,
    K_MOVE  = 3'd2,
    K_CR_RD = 3'd3,
    K_CR_WR = 3'd4
  } kind_e;
endpackage

// File: rtl/limm_decode.sv
`timescale 1ns/1ps
module limm_decode #(
  parameter int DATA_W    = limm_pkg::DATA_W,
  parameter int IDX_W     = limm_pkg::IDX_W,
  parameter int CONST_W   = limm_pkg::CONST_W,
  parameter int OPC_W     = limm_pkg::OPC_W,
  parameter int SRC_LSB   = limm_pkg::SRC_LSB,
  parameter int CONST_LSB = limm_pkg::CONST_LSB
) (
  input  logic [DATA_W-1:0]  instr,
  output limm_pkg::kind_e    kind,
  output logic               to_addr,
  output logic               flags_en,
  output logic               bad_opc,
  output logic [IDX_W-1:0]   dst,
  output logic [CONST_W-1:0] cval,
  output logic [DATA_W-1:0]  imm
);
  import limm_pkg::*;

  localparam int PAD_W = DATA_W - CONST_W;

  logic [OPC_W-1:0]  opc;
  logic [DATA_W-1:0] ext_s, ext_z, ext_hi;
  logic [IDX_W-1:0]  unused_src_idx;

  assign opc            = instr[OPC_W-1:0];
  assign cval           = instr[CONST_LSB +: CONST_W];
  assign dst            = instr[DATA_W-1 -: IDX_W];
  assign unused_src_idx = instr[SRC_LSB +: IDX_W];

  assign ext_s  = {{PAD_W{cval[CONST_W-1]}}, cval};
  assign ext_z  = {{PAD_W{1'b0}}, cval};
  assign ext_hi = {cval, {PAD_W{1'b0}}};

  always_comb begin
    kind     = K_NONE;
    to_addr  = 1'b0;
    flags_en = 1'b0;
    bad_opc  = 1'b0;
    imm      = ext_s;
    case (opc)
      OPC_ADD_IMM: begin
        kind = K_ADD; flags_en = 1'b1;
      end
      OPC_ADD_HI: begin
        kind = K_ADD; flags_en = 1'b1; imm = ext_hi;
      end
      OPC_ADD_HI_ADR: begin
        kind = K_ADD; to_addr = 1'b1; imm = ext_hi;
      end
      OPC_MOV_S:      kind = K_MOVE;
      OPC_MOV_Z: begin
        kind = K_MOVE; imm = ext_z;
      end
      OPC_MOV_HI: begin
        kind = K_MOVE; imm = ext_hi;
      end
      OPC_MOV_HI_ADR: begin
        kind = K_MOVE; to_addr = 1'b1; imm = ext_hi;
      end
      OPC_CR_READ:    kind = K_CR_RD;
      OPC_CR_WRITE:   kind = K_CR_WR;
      default:        bad_opc = 1'b1;
    endcase
  end
endmodule

// File: rtl/limm_adder.sv
`timescale 1ns/1ps
module limm_adder #(
  parameter int DATA_W = limm_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              ovf,
  output logic              aovf
);
  localparam int MSB = DATA_W - 1;

  assign sum  = a + b;
  assign ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign aovf = sum[MSB] ^ sum[MSB-1];
endmodule

// File: rtl/limm_exec_unit.sv
`timescale 1ns/1ps
module limm_exec_unit #(
  parameter int DATA_W  = limm_pkg::DATA_W,
  parameter int IDX_W   = limm_pkg::IDX_W,
  parameter int CONST_W = limm_pkg::CONST_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_instr,
  input  logic [DATA_W-1:0]  in_src,
  input  logic [DATA_W-1:0]  cr_rdata,
  output logic               wr_en,
  output logic               wr_addr_file,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [DATA_W-1:0]  wr_data,
  output logic               flag_upd,
  output logic               flag_v,
  output logic               flag_sv,
  output logic               flag_av,
  output logic               flag_sav,
  output logic               cr_rd_req,
  output logic               cr_wr_req,
  output logic [CONST_W-1:0] cr_addr,
  output logic [DATA_W-1:0]  cr_wdata,
  output logic               illegal
);
  import limm_pkg::*;

  kind_e              d_kind;
  logic               d_to_addr, d_flags_en, d_bad;
  logic [IDX_W-1:0]   d_dst;
  logic [CONST_W-1:0] d_cval;
  logic [DATA_W-1:0]  d_imm;
  logic [DATA_W-1:0]  a_sum;
  logic               a_ovf, a_aovf;
  logic               d_writes;

  limm_decode #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .CONST_W(CONST_W)
  ) u_dec (
    .instr(in_instr), .kind(d_kind), .to_addr(d_to_addr),
    .flags_en(d_flags_en), .bad_opc(d_bad), .dst(d_dst),
    .cval(d_cval), .imm(d_imm)
  );

  limm_adder #(.DATA_W(DATA_W)) u_add (
    .a(in_src), .b(d_imm), .sum(a_sum), .ovf(a_ovf), .aovf(a_aovf)
  );

  assign d_writes = (d_kind == K_ADD) || (d_kind == K_MOVE) || (d_kind == K_CR_RD);

  logic [DATA_W-1:0] res_q;
  logic              rd_q;

  // Control bits: cleared by reset, otherwise follow the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      flag_upd  <= 1'b0;
      rd_q      <= 1'b0;
      cr_wr_req <= 1'b0;
      illegal   <= 1'b0;
      flag_v    <= 1'b0;
      flag_av   <= 1'b0;
      flag_sv   <= 1'b0;
      flag_sav  <= 1'b0;
    end else begin
      wr_en     <= in_valid && d_writes;
      flag_upd  <= in_valid && d_flags_en;
      rd_q      <= in_valid && (d_kind == K_CR_RD);
      cr_wr_req <= in_valid && (d_kind == K_CR_WR);
      illegal   <= in_valid && d_bad;
      if (in_valid && d_flags_en) begin
        flag_v   <= a_ovf;
        flag_av  <= a_aovf;
        flag_sv  <= flag_sv | a_ovf;
        flag_sav <= flag_sav | a_aovf;
      end
    end
  end

  // Datapath registers: no reset, loaded only on a valid instruction.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      wr_idx       <= d_dst;
      wr_addr_file <= d_to_addr;
      res_q        <= (d_kind == K_ADD) ? a_sum : d_imm;
      cr_addr      <= d_cval;
      cr_wdata     <= in_src;
    end
  end

  assign cr_rd_req = rd_q;
  assign wr_data   = rd_q ? cr_rdata : res_q;
endmodule

// File: rtl/limm_exec_unit_chk.sv
`timescale 1ns/1ps
module limm_exec_unit_chk #(
  parameter int DATA_W  = limm_pkg::DATA_W,
  parameter int IDX_W   = limm_pkg::IDX_W,
  parameter int CONST_W = limm_pkg::CONST_W
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_instr,
  input logic [DATA_W-1:0]  in_src,
  input logic [DATA_W-1:0]  cr_rdata,
  input logic               wr_en,
  input logic               wr_addr_file,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [DATA_W-1:0]  wr_data,
  input logic               flag_upd,
  input logic               flag_v,
  input logic               flag_sv,
  input logic               flag_av,
  input logic               flag_sav,
  input logic               cr_rd_req,
  input logic               cr_wr_req,
  input logic [CONST_W-1:0] cr_addr,
  input logic [DATA_W-1:0]  cr_wdata,
  input logic               illegal
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wr_en && !flag_upd && !cr_rd_req && !cr_wr_req && !illegal);

  p_one_effect_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cr_rd_req, cr_wr_req, illegal}));

  p_addr_no_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr_file) |-> !flag_upd);

  p_sticky_v_r8: assert property (@(posedge clk) disable iff (rst)
    flag_upd |-> (flag_sv == ($past(flag_sv) | flag_v)));

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !flag_upd |-> ($stable(flag_sv) && $stable(flag_sav)));

  p_av_bits_r8: assert property (@(posedge clk) disable iff (rst)
    flag_upd |-> (flag_av == (wr_data[DATA_W-1] ^ wr_data[DATA_W-2])));

  p_cr_read_r9: assert property (@(posedge clk) disable iff (rst)
    cr_rd_req |-> (wr_en && !wr_addr_file && (wr_data == cr_rdata)));

  p_cr_write_r10: assert property (@(posedge clk) disable iff (rst)
    cr_wr_req |-> !wr_en);

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && !flag_upd && !cr_rd_req && !cr_wr_req));

  p_illegal_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (illegal && !$past(in_valid)) |-> 1'b0);
endmodule

bind limm_exec_unit limm_exec_unit_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .CONST_W(CONST_W)
) chk_i (.*);

// File: tb/limm_exec_unit_test.sv
`timescale 1ns/1ps
module limm_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [31:0] in_src = '0;
  logic [31:0] cr_rdata;
  logic        wr_en, wr_addr_file;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        flag_upd, flag_v, flag_sv, flag_av, flag_sav;
  logic        cr_rd_req, cr_wr_req;
  logic [15:0] cr_addr;
  logic [31:0] cr_wdata;
  logic        illegal;

  always #2.5 clk = ~clk;

  // Core register responder: data derived from the offset only.
  assign cr_rdata = {~cr_addr, cr_addr};

  limm_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_src(in_src), .cr_rdata(cr_rdata), .wr_en(wr_en),
    .wr_addr_file(wr_addr_file), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_upd(flag_upd), .flag_v(flag_v), .flag_sv(flag_sv),
    .flag_av(flag_av), .flag_sav(flag_sav), .cr_rd_req(cr_rd_req),
    .cr_wr_req(cr_wr_req), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
    .illegal(illegal)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    cmp_on = 1'b0;

  // Reference model state
  bit          m_wr, m_afile, m_fu, m_v, m_av, m_sv, m_sav, m_rd, m_cw, m_ill;
  logic [3:0]  m_idx;
  logic [31:0] m_data, m_wdata;
  logic [15:0] m_addr;
  string       m_tag = "R1";

  task automatic model_add(input logic [31:0] b, input bit addr_file, input string tag);
    longint s;
    logic [31:0] r;
    s = longint'($signed(in_src)) + longint'($signed(b));
    r = in_src + b;
    m_wr = 1; m_afile = addr_file; m_data = r; m_tag = tag;
    if (!addr_file) begin
      m_fu  = 1;
      m_v   = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      m_av  = r[31] ^ r[30];
      m_sv  = m_sv | m_v;
      m_sav = m_sav | m_av;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_wr = 0; m_fu = 0; m_rd = 0; m_cw = 0; m_ill = 0;
      m_sv = 0; m_sav = 0; m_tag = "R1";
    end else begin
      m_wr = 0; m_fu = 0; m_rd = 0; m_cw = 0; m_ill = 0; m_tag = "R2";
      if (in_valid) begin
        logic [15:0] c;
        logic [31:0] sx, hi;
        c  = in_instr[27:12];
        sx = {{16{c[15]}}, c};
        hi = {c, 16'h0000};
        m_idx = in_instr[31:28];
        m_afile = 0;
        case (in_instr[7:0])
          8'h10: model_add(sx, 0, "R3");
          8'h11: model_add(hi, 0, "R4");
          8'h12: model_add(hi, 1, "R5");
          8'h13: begin m_wr = 1; m_data = sx; m_tag = "R6"; end
          8'h14: begin m_wr = 1; m_data = {16'h0000, c}; m_tag = "R6"; end
          8'h15: begin m_wr = 1; m_data = hi; m_tag = "R7"; end
          8'h16: begin m_wr = 1; m_afile = 1; m_data = hi; m_tag = "R7"; end
          8'h17: begin m_wr = 1; m_rd = 1; m_addr = c; m_data = {~c, c}; m_tag = "R9"; end
          8'h18: begin m_cw = 1; m_addr = c; m_wdata = in_src; m_tag = "R10"; end
          default: begin m_ill = 1; m_tag = "R11"; end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(m_tag, "wr_en", 32'(wr_en), 32'(m_wr));
      chk(m_tag, "flag_upd", 32'(flag_upd), 32'(m_fu));
      chk(m_tag, "cr_rd_req", 32'(cr_rd_req), 32'(m_rd));
      chk(m_tag, "cr_wr_req", 32'(cr_wr_req), 32'(m_cw));
      chk(m_tag, "illegal", 32'(illegal), 32'(m_ill));
      chk("R8", "flag_sv", 32'(flag_sv), 32'(m_sv));
      chk("R8", "flag_sav", 32'(flag_sav), 32'(m_sav));
      if (m_wr) begin
        chk(m_tag, "wr_idx", 32'(wr_idx), 32'(m_idx));
        chk(m_tag, "wr_addr_file", 32'(wr_addr_file), 32'(m_afile));
        chk(m_tag, "wr_data", wr_data, m_data);
      end
      if (m_fu) begin
        chk("R8", "flag_v", 32'(flag_v), 32'(m_v));
        chk("R8", "flag_av", 32'(flag_av), 32'(m_av));
      end
      if (m_rd || m_cw) chk(m_tag, "cr_addr", 32'(cr_addr), 32'(m_addr));
      if (m_cw) chk(m_tag, "cr_wdata", cr_wdata, m_wdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [7:0] op, input logic [3:0] d,
                      input logic [15:0] c, input logic [31:0] src);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_instr = {d, c, 4'h5, op};
    in_src   = src;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b0;
      in_instr = $urandom;
      in_src   = $urandom;
    end
  endtask

  initial begin
    @(posedge clk); #1;
    cmp_on = 1'b1;          // R1: reset state checked from here
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    idle(3);                // R2: quiet with garbage instruction, no valid
    send(8'h10, 4'd3, 16'h0005, 32'd100);        // R3 positive
    send(8'h10, 4'd1, 16'hFFFF, 32'd0);          // R3 negative constant
    send(8'h10, 4'd2, 16'h0001, 32'h7FFF_FFFF);  // R8 positive overflow
    send(8'h12, 4'd4, 16'h0001, 32'h0000_0001);  // R5 sticky untouched
    send(8'h10, 4'd6, 16'h8000, 32'h8000_0000);  // R8 negative overflow
    send(8'h11, 4'd7, 16'h4000, 32'h4000_0000);  // R4 overflow
    send(8'h11, 4'd8, 16'h1234, 32'h0000_5678);  // R4
    send(8'h13, 4'd9, 16'h8000, 32'hFFFF_FFFF);  // R6 signed
    send(8'h14, 4'd10, 16'h8000, 32'hFFFF_FFFF); // R6 unsigned
    send(8'h14, 4'd11, 16'hFFFF, 32'd0);         // R6 max
    send(8'h15, 4'd12, 16'hABCD, 32'd7);         // R7 data
    send(8'h16, 4'd13, 16'h00FF, 32'd7);         // R7 address
    send(8'h17, 4'd14, 16'hFE04, 32'd0);         // R9
    send(8'h18, 4'd15, 16'h9400, 32'hDEAD_BEEF); // R10
    send(8'h00, 4'd1, 16'h1111, 32'd1);          // R11
    send(8'hFF, 4'd2, 16'h2222, 32'd2);          // R11
    send(8'h19, 4'd3, 16'h3333, 32'd3);          // R11
    idle(2);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) idle(1);
      else send(8'h0E + 8'($urandom_range(11)), 4'($urandom),
                16'($urandom), $urandom);
    end
    idle(1);
    @(negedge clk); #1; rst = 1'b1;              // R1: second reset clears sticky
    repeat (2) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    idle(3);
    @(negedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule